// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B. It has one storage register for each direction. For each direction it can forward the live value on the opposite bus, or the word held in that direction's register. It can also leave both buses undriven. Each bus appears as three ports: an input value, an output value and an output-enable. There are no internal tristates, and the surrounding logic or pads resolve the bus.

The A-side and B-side capture strobes are asynchronous-style inputs. They are sampled in the system clock domain, and each rising transition loads the matching register. Capture always runs, whatever the output-enable state. Each register loads what is actually on its bus. So when the block drives a bus, the register on that side stores the driven word, and this gives a path that copies one word into both registers.

Two parameters fix the variant. The first is the control style: an active-low enable with a direction pin, or two independent per-direction enables. The second sets the output polarity, either true or complemented.

Top module: `regxcvr_top`

## Requirements
- R1: A rising transition on `cap_a` is first seen at a system clock edge. At the next system edge, the A register loads the A bus value: `a_out` when `a_oe` is 1, otherwise `a_in`. Between such loads the A register holds its value.
- R2: A rising transition on `cap_b` loads the B register with the B bus value (`b_out` when `b_oe` is 1, otherwise `b_in`), with the same two-edge timing as R1. Between loads the B register holds its value.
- R3: When `sel_a2b` is 0, `b_out` carries live `a_in`. When it is 1, `b_out` carries the A register. `sel_b2a` chooses between `b_in` and the B register for `a_out` in the same way.
- R4: In enable/direction style (CTRL = CTRL_EN_DIR), `en_n` = 1 holds both `a_oe` and `b_oe` at 0, and the registers still capture.
- R5: In enable/direction style with `en_n` = 0, `dir` = 0 drives A (`a_oe` = 1) and `dir` = 1 drives B (`b_oe` = 1). Both enables are never 1 together.
- R6: In dual-enable style (CTRL = CTRL_DUAL_EN), `b_oe` follows `en_a2b` (active high) and `a_oe` follows the inverse of `en_b2a_n` (active low). Both buses may be driven at once.
- R7: When a bus is driven from live data, a capture on that bus's side stores the forwarded word. With B driven from live A, one simultaneous `cap_a`/`cap_b` pair leaves the A word in both registers.
- R8: When a driven bus carries stored data and both strobes rise together, the receiving register takes the value the opposite register held before that edge. With both selects 1 in dual-enable style, the two registers exchange contents (complemented in the inverting variant).
- R9: With INVERT = 1, every output word is the bitwise complement of the selected live or stored word. With INVERT = 0, it is unchanged.
- R10: A synchronous active-high `rst` clears both registers to zero, and `a_oe` and `b_oe` are 0 in every cycle in which `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Word the block puts on bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Word the block puts on bus B |
| b_oe | output | 1 | Block drives bus B |
| cap_a | input | 1 | Capture strobe for the A register, rising active |
| cap_b | input | 1 | Capture strobe for the B register, rising active |
| sel_a2b | input | 1 | Source for B: 0 live A, 1 A register |
| sel_b2a | input | 1 | Source for A: 0 live B, 1 B register |
| en_n | input | 1 | Active-low enable, enable/direction style |
| dir | input | 1 | Direction, 1 drives B, enable/direction style |
| en_a2b | input | 1 | Active-high B-drive enable, dual-enable style |
| en_b2a_n | input | 1 | Active-low A-drive enable, dual-enable style |

## Verification
The bench uses two instances: enable/direction style with true outputs, and dual-enable style with inverted outputs. It compares both against a reference model.

- **Isolated capture.** The bench captures while the buses are isolated. A design that gated capture with the enable would show a stale word once stored data is selected.
- **Copy-through.** It drives B from live A and fires both strobes at once. A register fed from `b_in` instead of the driven word would miss the copy.
- **Register exchange.** It fires both strobes together with both selects on stored data. A design that passes the new value through in the same edge would duplicate one word instead of exchanging the pair.
- **Polarity and contention.** Random cycles mix both polarities and every enable combination. Any slip in polarity or enable decode, including driving a bus the bench itself drives, shows up as a mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        CTRL_EN_DIR  = 1'b0,
        CTRL_DUAL_EN = 1'b1
    } ctrl_style_e;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } oe_pair_t;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_A    = 0;
    localparam int SIDE_B    = 1;

    function automatic oe_pair_t decode_en_dir(input logic en_n, input logic dir);
        oe_pair_t r;
        r.drive_a = ~en_n & ~dir;
        r.drive_b = ~en_n & dir;
        return r;
    endfunction

    function automatic oe_pair_t decode_dual(input logic en_a2b, input logic en_b2a_n);
        oe_pair_t r;
        r.drive_a = ~en_b2a_n;
        r.drive_b = en_a2b;
        return r;
    endfunction

endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign rise_o = stage1_q & ~stage2_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
    parameter int WIDTH  = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic [WIDTH-1:0]  live_i,
    input  logic [WIDTH-1:0]  stored_i,
    input  xcvr_pkg::src_sel_e sel_i,
    output logic [WIDTH-1:0]  y_o
);
    logic [WIDTH-1:0] picked;

    always_comb begin
        unique case (sel_i)
            xcvr_pkg::SRC_STORED: picked = stored_i;
            default:              picked = live_i;
        endcase
    end

    generate
        if (INVERT) begin : g_inv
            assign y_o = ~picked;
        end else begin : g_true
            assign y_o = picked;
        end
    endgenerate
endmodule

// File: rtl/xcvr_oe_decode.sv
module xcvr_oe_decode #(
    parameter xcvr_pkg::ctrl_style_e CTRL = xcvr_pkg::CTRL_EN_DIR
) (
    input  logic               rst,
    input  logic               en_n,
    input  logic               dir,
    input  logic               en_a2b,
    input  logic               en_b2a_n,
    output xcvr_pkg::oe_pair_t oe_o
);
    xcvr_pkg::oe_pair_t raw;
    logic unused_pins;

    generate
        if (CTRL == xcvr_pkg::CTRL_DUAL_EN) begin : g_dual
            assign raw         = xcvr_pkg::decode_dual(en_a2b, en_b2a_n);
            assign unused_pins = en_n ^ dir;
        end else begin : g_endir
            assign raw         = xcvr_pkg::decode_en_dir(en_n, dir);
            assign unused_pins = en_a2b ^ en_b2a_n;
        end
    endgenerate

    always_comb begin
        oe_o = raw;
        if (rst) begin
            oe_o.drive_a = 1'b0;
            oe_o.drive_b = 1'b0;
        end
    end
endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
    parameter int                    WIDTH  = 8,
    parameter xcvr_pkg::ctrl_style_e CTRL   = xcvr_pkg::CTRL_EN_DIR,
    parameter bit                    INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             sel_a2b,
    input  logic             sel_b2a,
    input  logic             en_n,
    input  logic             dir,
    input  logic             en_a2b,
    input  logic             en_b2a_n
);
    import xcvr_pkg::*;

    oe_pair_t         oe;
    logic [NUM_SIDES-1:0] strobe_raw;
    logic [NUM_SIDES-1:0] strobe_rise;
    logic [WIDTH-1:0]     bus_seen [NUM_SIDES];
    logic [WIDTH-1:0]     held_q   [NUM_SIDES];
    logic [WIDTH-1:0]     reg_a_q;
    logic [WIDTH-1:0]     reg_b_q;

    assign strobe_raw[SIDE_A] = cap_a;
    assign strobe_raw[SIDE_B] = cap_b;

    xcvr_oe_decode #(.CTRL(CTRL)) u_oe (
        .rst      (rst),
        .en_n     (en_n),
        .dir      (dir),
        .en_a2b   (en_a2b),
        .en_b2a_n (en_b2a_n),
        .oe_o     (oe)
    );

    assign a_oe = oe.drive_a;
    assign b_oe = oe.drive_b;

    // Each register sees its bus as resolved: the driven word wins.
    always_comb begin
        bus_seen[SIDE_A] = oe.drive_a ? a_out : a_in;
        bus_seen[SIDE_B] = oe.drive_b ? b_out : b_in;
    end

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            xcvr_edge_sense u_edge (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (strobe_raw[s]),
                .rise_o (strobe_rise[s])
            );
            xcvr_store #(.WIDTH(WIDTH)) u_store (
                .clk    (clk),
                .rst    (rst),
                .load_i (strobe_rise[s]),
                .d_i    (bus_seen[s]),
                .q_o    (held_q[s])
            );
        end
    endgenerate

    assign reg_a_q = held_q[SIDE_A];
    assign reg_b_q = held_q[SIDE_B];

    xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
        .live_i   (a_in),
        .stored_i (reg_a_q),
        .sel_i    (src_sel_e'(sel_a2b)),
        .y_o      (b_out)
    );

    xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
        .live_i   (b_in),
        .stored_i (reg_b_q),
        .sel_i    (src_sel_e'(sel_b2a)),
        .y_o      (a_out)
    );
endmodule

// File: rtl/regxcvr_checker.sv
module regxcvr_checker #(
    parameter int                    WIDTH  = 8,
    parameter xcvr_pkg::ctrl_style_e CTRL   = xcvr_pkg::CTRL_EN_DIR,
    parameter bit                    INVERT = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             cap_a,
    input logic             cap_b,
    input logic             sel_a2b,
    input logic             sel_b2a,
    input logic             en_n,
    input logic             dir,
    input logic             en_a2b,
    input logic             en_b2a_n,
    input logic [WIDTH-1:0] reg_a_q,
    input logic [WIDTH-1:0] reg_b_q
);
    logic ca1, ca2, cb1, cb2;
    logic a_rise, b_rise;
    logic unused_chk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ca1 <= 1'b0; ca2 <= 1'b0; cb1 <= 1'b0; cb2 <= 1'b0;
        end else begin
            ca1 <= cap_a; ca2 <= ca1; cb1 <= cap_b; cb2 <= cb1;
        end
    end
    assign a_rise = ca1 & ~ca2;
    assign b_rise = cb1 & ~cb2;

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> (!a_oe && !b_oe));

    assert_cap_a_R1: assert property (@(posedge clk) disable iff (rst)
        a_rise |=> (reg_a_q == $past(a_oe ? a_out : a_in)));

    assert_hold_a_R1: assert property (@(posedge clk) disable iff (rst)
        !a_rise |=> $stable(reg_a_q));

    assert_cap_b_R2: assert property (@(posedge clk) disable iff (rst)
        b_rise |=> (reg_b_q == $past(b_oe ? b_out : b_in)));

    assert_hold_b_R2: assert property (@(posedge clk) disable iff (rst)
        !b_rise |=> $stable(reg_b_q));

    assert_stored_to_b_R3: assert property (@(posedge clk) disable iff (rst)
        (b_oe && sel_a2b) |-> (b_out == (INVERT ? ~reg_a_q : reg_a_q)));

    assert_live_to_a_R9: assert property (@(posedge clk) disable iff (rst)
        (a_oe && !sel_b2a) |-> (a_out == (INVERT ? ~b_in : b_in)));

    generate
        if (CTRL == xcvr_pkg::CTRL_EN_DIR) begin : g_endir
            assert_isolate_R4: assert property (@(posedge clk) disable iff (rst)
                en_n |-> (!a_oe && !b_oe));
            assert_one_side_R5: assert property (@(posedge clk) disable iff (rst)
                !(a_oe && b_oe));
            assign unused_chk = en_a2b ^ en_b2a_n ^ dir;
        end else begin : g_dual
            assert_both_driven_R6: assert property (@(posedge clk) disable iff (rst)
                (en_a2b && !en_b2a_n) |-> (a_oe && b_oe));
            assert_b_enable_R6: assert property (@(posedge clk) disable iff (rst)
                b_oe == en_a2b);
            assign unused_chk = en_n ^ dir;
        end
    endgenerate
endmodule

bind regxcvr_top regxcvr_checker #(
    .WIDTH(WIDTH), .CTRL(CTRL), .INVERT(INVERT)
) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_a(cap_a), .cap_b(cap_b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .en_n(en_n), .dir(dir),
    .en_a2b(en_a2b), .en_b2a_n(en_b2a_n), .reg_a_q(reg_a_q), .reg_b_q(reg_b_q)
);

// File: tb/tb_regxcvr_top.sv
module tb_regxcvr_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int RAND_ITERS = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic cap_a = 0, cap_b = 0, sel_a2b = 0, sel_b2a = 0;
    logic en_n = 1, dir = 0, en_a2b = 0, en_b2a_n = 1;

    logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
    logic a_oe0, b_oe0, a_oe1, b_oe1;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [W-1:0] mA [2];
    logic [W-1:0] mB [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    regxcvr_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
        .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0), .cap_a(cap_a), .cap_b(cap_b),
        .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .en_n(en_n), .dir(dir),
        .en_a2b(en_a2b), .en_b2a_n(en_b2a_n)
    );

    regxcvr_top #(.WIDTH(W), .CTRL(xcvr_pkg::CTRL_DUAL_EN), .INVERT(1'b1)) dut_dual (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
        .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1), .cap_a(cap_a), .cap_b(cap_b),
        .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .en_n(en_n), .dir(dir),
        .en_a2b(en_a2b), .en_b2a_n(en_b2a_n)
    );

    function automatic logic [W-1:0] pol(input int k, input logic [W-1:0] v);
        return (k == 1) ? ~v : v;
    endfunction
    function automatic logic exp_a_oe(input int k);
        if (rst) return 1'b0;
        return (k == 0) ? (!en_n && !dir) : !en_b2a_n;
    endfunction
    function automatic logic exp_b_oe(input int k);
        if (rst) return 1'b0;
        return (k == 0) ? (!en_n && dir) : en_a2b;
    endfunction
    function automatic logic [W-1:0] exp_a_out(input int k);
        return pol(k, sel_b2a ? mB[k] : b_in);
    endfunction
    function automatic logic [W-1:0] exp_b_out(input int k);
        return pol(k, sel_a2b ? mA[k] : a_in);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        for (int k = 0; k < 2; k++) begin
            logic aoe, boe;
            logic [W-1:0] ao, bo;
            aoe = (k == 0) ? a_oe0 : a_oe1;
            boe = (k == 0) ? b_oe0 : b_oe1;
            ao  = (k == 0) ? a_out0 : a_out1;
            bo  = (k == 0) ? b_out0 : b_out1;
            chk(aoe == exp_a_oe(k), $sformatf("R5/R6 a_oe inst%0d %s", k, ctx), {7'd0, aoe}, {7'd0, exp_a_oe(k)});
            chk(boe == exp_b_oe(k), $sformatf("R5/R6 b_oe inst%0d %s", k, ctx), {7'd0, boe}, {7'd0, exp_b_oe(k)});
            if (exp_a_oe(k))
                chk(ao == exp_a_out(k), $sformatf("R3/R9 a_out inst%0d %s", k, ctx), ao, exp_a_out(k));
            if (exp_b_oe(k))
                chk(bo == exp_b_out(k), $sformatf("R3/R9 b_out inst%0d %s", k, ctx), bo, exp_b_out(k));
        end
        // contention: the bench drives a bus only when neither instance should
        if (!(exp_a_oe(0) || exp_a_oe(1)))
            chk(!(a_oe0 || a_oe1), $sformatf("R5 contention on A %s", ctx), {7'd0, a_oe0 | a_oe1}, 8'd0);
        if (!(exp_b_oe(0) || exp_b_oe(1)))
            chk(!(b_oe0 || b_oe1), $sformatf("R6 contention on B %s", ctx), {7'd0, b_oe0 | b_oe1}, 8'd0);
    endtask

    // Strobe pulse with model update from the pre-pulse resolved buses (R1, R2, R7, R8).
    task automatic strobe(input bit pa, input bit pb);
        logic [W-1:0] ra [2];
        logic [W-1:0] rb [2];
        for (int k = 0; k < 2; k++) begin
            ra[k] = exp_a_oe(k) ? exp_a_out(k) : a_in;
            rb[k] = exp_b_oe(k) ? exp_b_out(k) : b_in;
        end
        @(negedge clk);
        cap_a = pa; cap_b = pb;
        repeat (3) @(negedge clk);
        cap_a = 0; cap_b = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            if (pa) mA[k] = ra[k];
            if (pb) mB[k] = rb[k];
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0017);
        mA[0] = '0; mA[1] = '0; mB[0] = '0; mB[1] = '0;
        en_n = 0; dir = 1; en_a2b = 1; en_b2a_n = 0;
        repeat (3) @(negedge clk);
        // R10: enables held low while reset asserted
        chk(!(a_oe0 | b_oe0 | a_oe1 | b_oe1), "R10 oe during reset",
            {4'd0, a_oe0, b_oe0, a_oe1, b_oe1}, 8'd0);
        rst = 0;
        sel_a2b = 1; sel_b2a = 1;
        @(negedge clk);
        chk(b_out0 == 8'h00, "R10 A register cleared", b_out0, 8'h00);
        chk(a_out1 == 8'hFF, "R10 B register cleared (inverted)", a_out1, 8'hFF);
        check_all("after reset");

        // R4: isolated capture in enable/direction style
        en_n = 1; en_a2b = 0; en_b2a_n = 1;
        a_in = 8'h3C; b_in = 8'hC5;
        @(negedge clk);
        check_all("R4 isolated");
        strobe(1, 1);
        en_n = 0; dir = 1; sel_a2b = 1;
        @(negedge clk);
        chk(b_out0 == 8'h3C, "R4 capture while isolated", b_out0, 8'h3C);
        check_all("R4 readback");

        // R7: copy-through with live select, simultaneous strobes
        dir = 1; sel_a2b = 0; a_in = 8'h5A; b_in = 8'h00;
        strobe(1, 1);
        dir = 0; sel_b2a = 1;
        @(negedge clk);
        chk(a_out0 == 8'h5A, "R7 A word in B register", a_out0, 8'h5A);
        check_all("R7");

        // R8: register exchange in dual-enable inverting instance
        en_n = 1; en_a2b = 0; en_b2a_n = 1;
        a_in = 8'h11; b_in = 8'h22;
        strobe(1, 1);
        en_a2b = 1; en_b2a_n = 0; sel_a2b = 1; sel_b2a = 1;
        @(negedge clk);
        chk(a_out1 == 8'hDD, "R6 both driven stored A side", a_out1, 8'hDD);
        chk(b_out1 == 8'hEE, "R6 both driven stored B side", b_out1, 8'hEE);
        strobe(1, 1);
        @(negedge clk);
        chk(a_out1 == 8'h11, "R8 exchange A side", a_out1, 8'h11);
        chk(b_out1 == 8'h22, "R8 exchange B side", b_out1, 8'h22);
        check_all("R8");

        // R1 R2 R9: constrained random mix
        for (int i = 0; i < RAND_ITERS; i++) begin
            int r;
            @(negedge clk);
            a_in = W'($urandom); b_in = W'($urandom);
            r = int'($urandom % 64);
            sel_a2b = r[0]; sel_b2a = r[1];
            en_n = (r[5:2] == 4'd0); dir = r[2];
            en_a2b = r[3]; en_b2a_n = r[4];
            #1;
            check_all($sformatf("rand %0d", i));
            case ($urandom % 4)
                0: ;
                1: strobe(1, 0);
                2: strobe(0, 1);
                default: strobe(1, 1);
            endcase
            check_all($sformatf("rand post %0d R1 R2", i));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule